// File: doc/BRIEF.md
# Handshake Command/Response Sequencer

This block is the device-side engine of a byte-serial command channel. A host writes a small port register that carries two active-low handshake lines, a request line driven by the host and an acknowledge line driven back by the device. Each byte moves through a shift-register byte whose direction flag says which way it travels. The sequencer watches the port register for changes, classifies the two lines, and consumes or produces one byte per valid request. It pulses a shift-done strobe for every byte it accepts.

A transaction starts with a command code. A length lookup on the code gives the argument count and the reply count. Either count can instead travel in-band. The arguments are stored in a buffer that a dispatcher reads. The sequencer raises a dispatch request, takes back a hit flag, a reply length and the reply bytes, and then clocks the reply out one byte per request. A command the dispatcher does not recognise gets an all-zero reply.

Top module: `hs_cmd_seq`

## Requirements
- R1: After reset the port register reads 0x18 (request bit 4 and acknowledge bit 3 both high), the sequencer is idle, and neither the dispatch request nor the shift-done strobe is asserted.
- R2: The block acts only when the port register differs from the last value it handled. Writing 0x18 while idle changes nothing.
- R3: Request low with acknowledge high is a valid request. The block drives acknowledge (bit 3) low and, when the direction fits, accepts one byte and pulses shift-done once.
- R4: Request high with acknowledge low is an acknowledge release. The block sets acknowledge high again, so the port reads 0x18, and does nothing else.
- R5: Both lines low is a protocol error. The acknowledge bit is left as written, no byte is taken, no strobe is given and the sequencer state is kept.
- R6: The direction flag must be 1 (host to device) in the idle and argument phases and 0 (device to host) in the reply phase. On a mismatch the request is still acknowledged, but the byte is skipped with no shift-done and the phase is unchanged.
- R7: The command code sets the counts. Code bits [2:0] give the argument count and bits [5:3] give the reply count. The value 7 in either field means that count travels in-band.
- R8: With an in-band argument count, the first byte after the command is the count. The count byte is not stored as an argument.
- R9: Once the last argument arrives, the dispatch request is raised with the command and the argument count. Argument i is readable at address i of the argument port, with one cycle of read latency. The request holds until dispatch-done.
- R10: Reply bytes go out in order, one per valid request. Byte i comes from reply-buffer address i when the command was recognised and i is below the dispatcher's length; otherwise the byte is zero. After the last byte the sequencer is idle.
- R11: With an in-band reply count, the first byte sent back is the reply size, which equals the dispatcher's length for a recognised command. That many bytes follow.
- R12: An unrecognised command with a fixed reply count returns that many zero bytes. With an in-band reply count it returns a single size byte of zero.
- R13: Arguments beyond the 32-entry buffer are dropped, but the count still advances. Dispatch happens after the full count, and the first 32 arguments are intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_we | input | 1 | Host write strobe for the port register |
| port_wdata | input | 8 | Value the host writes to the port register |
| port_q | output | 8 | Port register contents, including the acknowledge bit driven by the block |
| sr_to_dev | input | 1 | Shift direction: 1 host to device, 0 device to host |
| sr_wdata | input | 8 | Byte shifted in by the host |
| sr_rdata | output | 8 | Byte presented to the host in the reply phase |
| sr_done | output | 1 | One-cycle pulse per accepted byte |
| disp_req | output | 1 | Dispatch request, held until dispatch-done |
| disp_cmd | output | 8 | Command code under dispatch |
| disp_argc | output | 8 | Argument count of the command |
| arg_raddr | input | 5 | Argument buffer read address |
| arg_rdata | output | 8 | Argument buffer read data, one cycle after the address |
| disp_done | input | 1 | Dispatcher completion pulse |
| disp_hit | input | 1 | Command recognised by the dispatcher |
| disp_len | input | 8 | Reply length produced by the dispatcher |
| rsp_we | input | 1 | Reply buffer write strobe |
| rsp_waddr | input | 5 | Reply buffer write address |
| rsp_wdata | input | 8 | Reply buffer write data |

## Verification
The assertions take the host to be well behaved. A port write is held for one cycle, and two consecutive host writes are never closer than a cycle the engine can use. The dispatcher fills the reply buffer before it pulses dispatch-done and pulses it only while a dispatch is pending. The bench host only writes the port after it has seen the acknowledge settle. The bench dispatcher writes only while the dispatch request is high and then gives exactly one done pulse. Under these conditions the one-cycle implications on acknowledge, phase and strobe hold.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    LN_IDLE,
    LN_REQ,
    LN_REL,
    LN_ERR
  } line_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ARGS,
    SQ_DISP,
    SQ_REPLY
  } seq_e;

  typedef struct packed {
    logic              arg_inband;
    logic [BYTE_W-1:0] arg_len;
    logic              rsp_inband;
    logic [BYTE_W-1:0] rsp_len;
  } len_t;

  // Length lookup: low field gives the argument count, next field the reply
  // count; an all-ones field marks an in-band count.
  function automatic len_t lookup_len(input logic [BYTE_W-1:0] code);
    len_t r;
    r.arg_inband = &code[2:0];
    r.arg_len    = {{(BYTE_W-3){1'b0}}, code[2:0]};
    r.rsp_inband = &code[5:3];
    r.rsp_len    = {{(BYTE_W-3){1'b0}}, code[5:3]};
    return r;
  endfunction

endpackage

// File: rtl/hs_line_class.sv
module hs_line_class
  import hs_seq_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int REQ_BIT = 4,
  parameter int ACK_BIT = 3
) (
  input  logic [PORT_W-1:0] port_val,
  output line_e             cls
);

  logic req_hi, ack_hi;

  assign req_hi = port_val[REQ_BIT];
  assign ack_hi = port_val[ACK_BIT];

  always_comb begin
    case ({req_hi, ack_hi})
      2'b11:   cls = LN_IDLE;
      2'b01:   cls = LN_REQ;
      2'b10:   cls = LN_REL;
      default: cls = LN_ERR;
    endcase
  end

endmodule

// File: rtl/hs_sdp_ram.sv
module hs_sdp_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/hs_seq_core.sv
module hs_seq_core
  import hs_seq_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int REQ_BIT   = 4,
  parameter int ACK_BIT   = 3,
  parameter int BUF_DEPTH = 32,
  localparam int AW       = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_we,
  input  logic [PORT_W-1:0] port_wdata,
  output logic [PORT_W-1:0] port_q,
  input  line_e             cls,
  input  logic              sr_to_dev,
  input  logic [BYTE_W-1:0] sr_wdata,
  output logic [BYTE_W-1:0] sr_rdata,
  output logic              sr_done,
  output logic              disp_req,
  output logic [BYTE_W-1:0] disp_cmd,
  output logic [BYTE_W-1:0] disp_argc,
  input  logic              disp_done,
  input  logic              disp_hit,
  input  logic [BYTE_W-1:0] disp_len,
  output logic              arg_we,
  output logic [AW-1:0]     arg_waddr,
  output logic [BYTE_W-1:0] arg_wdata,
  output logic [AW-1:0]     rsp_raddr,
  input  logic [BYTE_W-1:0] rsp_rdata
);

  localparam logic [PORT_W-1:0] ACK_MASK  = PORT_W'(1) << ACK_BIT;
  localparam logic [PORT_W-1:0] REQ_MASK  = PORT_W'(1) << REQ_BIT;
  localparam logic [PORT_W-1:0] IDLE_PORT = ACK_MASK | REQ_MASK;
  localparam logic [BYTE_W:0]   DEPTH_V   = (BYTE_W+1)'(BUF_DEPTH);

  seq_e              st, n_st;
  logic [PORT_W-1:0] last_q;
  logic [BYTE_W-1:0] cmd_q, n_cmd;
  logic              ainb_q, n_ainb, rinb_q, n_rinb;
  logic [BYTE_W-1:0] alen_q, n_alen, apos_q, n_apos;
  logic [BYTE_W-1:0] rlen_q, n_rlen, rpos_q, n_rpos;
  logic              hit_q, n_hit;
  logic [BYTE_W-1:0] dlen_q, n_dlen;
  logic [BYTE_W-1:0] rdata_q, n_rdata;
  logic              done_q, n_done;
  logic              awe_q, n_awe;
  logic [AW-1:0]     awaddr_q;
  logic [BYTE_W-1:0] awdata_q;
  logic              act, dir_ok, byte_ok;
  len_t              lk;

  assign act     = (st != SQ_DISP) && !port_we && (port_q != last_q);
  assign dir_ok  = (st == SQ_REPLY) ? !sr_to_dev : sr_to_dev;
  assign byte_ok = act && (cls == LN_REQ) && dir_ok;
  assign lk      = lookup_len(sr_wdata);

  always_comb begin
    n_st    = st;
    n_cmd   = cmd_q;
    n_ainb  = ainb_q;
    n_alen  = alen_q;
    n_apos  = apos_q;
    n_rinb  = rinb_q;
    n_rlen  = rlen_q;
    n_rpos  = rpos_q;
    n_hit   = hit_q;
    n_dlen  = dlen_q;
    n_rdata = rdata_q;
    n_done  = 1'b0;
    n_awe   = 1'b0;
    if (byte_ok) begin
      n_done = 1'b1;
      case (st)
        SQ_IDLE: begin
          n_cmd  = sr_wdata;
          n_ainb = lk.arg_inband;
          n_alen = lk.arg_len;
          n_rinb = lk.rsp_inband;
          n_rlen = lk.rsp_len;
          n_apos = '0;
          n_rpos = '0;
          n_st   = SQ_ARGS;
        end
        SQ_ARGS: begin
          if (ainb_q) begin
            n_ainb = 1'b0;
            n_alen = sr_wdata;
          end else begin
            n_awe  = ({1'b0, apos_q} < DEPTH_V);
            n_apos = apos_q + 1'b1;
          end
        end
        SQ_REPLY: begin
          if (rinb_q) begin
            n_rinb  = 1'b0;
            n_rdata = rlen_q;
          end else begin
            n_rdata = (hit_q && (rpos_q < dlen_q) && ({1'b0, rpos_q} < DEPTH_V))
                      ? rsp_rdata : '0;
            n_rpos  = rpos_q + 1'b1;
          end
        end
        default: ;
      endcase
      if ((n_st == SQ_ARGS) && !n_ainb && (n_apos == n_alen)) n_st = SQ_DISP;
      if ((n_st == SQ_REPLY) && !n_rinb && (n_rpos == n_rlen)) n_st = SQ_IDLE;
    end else if ((st == SQ_DISP) && disp_done) begin
      n_hit  = disp_hit;
      n_dlen = disp_len;
      n_rpos = '0;
      if (rinb_q) n_rlen = disp_hit ? disp_len : '0;
      n_st = (!rinb_q && (rlen_q == '0)) ? SQ_IDLE : SQ_REPLY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q   <= IDLE_PORT;
      last_q   <= IDLE_PORT;
      st       <= SQ_IDLE;
      cmd_q    <= '0;
      ainb_q   <= 1'b0;
      alen_q   <= '0;
      apos_q   <= '0;
      rinb_q   <= 1'b0;
      rlen_q   <= '0;
      rpos_q   <= '0;
      hit_q    <= 1'b0;
      dlen_q   <= '0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
      awe_q    <= 1'b0;
      awaddr_q <= '0;
      awdata_q <= '0;
    end else begin
      if (port_we) begin
        port_q <= port_wdata;
      end else if (act) begin
        case (cls)
          LN_REL: begin
            port_q <= port_q | ACK_MASK;
            last_q <= port_q | ACK_MASK;
          end
          LN_REQ: begin
            port_q <= port_q & ~ACK_MASK;
            last_q <= port_q & ~ACK_MASK;
          end
          default: last_q <= port_q;
        endcase
      end
      st       <= n_st;
      cmd_q    <= n_cmd;
      ainb_q   <= n_ainb;
      alen_q   <= n_alen;
      apos_q   <= n_apos;
      rinb_q   <= n_rinb;
      rlen_q   <= n_rlen;
      rpos_q   <= n_rpos;
      hit_q    <= n_hit;
      dlen_q   <= n_dlen;
      rdata_q  <= n_rdata;
      done_q   <= n_done;
      awe_q    <= n_awe;
      awaddr_q <= apos_q[AW-1:0];
      awdata_q <= sr_wdata;
    end
  end

  assign sr_rdata  = rdata_q;
  assign sr_done   = done_q;
  assign disp_req  = (st == SQ_DISP);
  assign disp_cmd  = cmd_q;
  assign disp_argc = alen_q;
  assign arg_we    = awe_q;
  assign arg_waddr = awaddr_q;
  assign arg_wdata = awdata_q;
  assign rsp_raddr = rpos_q[AW-1:0];

  // R3
  req_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (act && cls == LN_REQ) |=> (port_q[ACK_BIT] == 1'b0));

  // R4
  rel_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (act && cls == LN_REL) |=> (port_q[ACK_BIT] == 1'b1) && !sr_done);

  // R5
  err_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (act && cls == LN_ERR) |=> (st == $past(st)) && !sr_done);

  // R6
  dir_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (act && cls == LN_REQ && !dir_ok) |=> (st == $past(st)) && !sr_done);

  // R9
  disp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_req && !disp_done) |=> disp_req);

  // R2
  no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (!port_we && port_q == last_q) |=> !sr_done);

endmodule

// File: rtl/hs_cmd_seq.sv
module hs_cmd_seq
  import hs_seq_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int REQ_BIT   = 4,
  parameter int ACK_BIT   = 3,
  parameter int BUF_DEPTH = 32,
  localparam int AW       = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_we,
  input  logic [PORT_W-1:0] port_wdata,
  output logic [PORT_W-1:0] port_q,
  input  logic              sr_to_dev,
  input  logic [7:0]        sr_wdata,
  output logic [7:0]        sr_rdata,
  output logic              sr_done,
  output logic              disp_req,
  output logic [7:0]        disp_cmd,
  output logic [7:0]        disp_argc,
  input  logic [AW-1:0]     arg_raddr,
  output logic [7:0]        arg_rdata,
  input  logic              disp_done,
  input  logic              disp_hit,
  input  logic [7:0]        disp_len,
  input  logic              rsp_we,
  input  logic [AW-1:0]     rsp_waddr,
  input  logic [7:0]        rsp_wdata
);

  line_e             cls;
  logic              arg_we;
  logic [AW-1:0]     arg_waddr;
  logic [BYTE_W-1:0] arg_wdata;
  logic [AW-1:0]     rsp_raddr;
  logic [BYTE_W-1:0] rsp_rdata;

  hs_line_class #(.PORT_W(PORT_W), .REQ_BIT(REQ_BIT), .ACK_BIT(ACK_BIT)) u_cls (
    .port_val (port_q),
    .cls      (cls)
  );

  hs_seq_core #(
    .PORT_W(PORT_W), .REQ_BIT(REQ_BIT), .ACK_BIT(ACK_BIT), .BUF_DEPTH(BUF_DEPTH)
  ) u_core (
    .clk, .rst, .port_we, .port_wdata, .port_q, .cls,
    .sr_to_dev, .sr_wdata, .sr_rdata, .sr_done,
    .disp_req, .disp_cmd, .disp_argc, .disp_done, .disp_hit, .disp_len,
    .arg_we, .arg_waddr, .arg_wdata, .rsp_raddr, .rsp_rdata
  );

  hs_sdp_ram #(.DEPTH(BUF_DEPTH), .W(BYTE_W)) u_arg_ram (
    .clk, .we(arg_we), .waddr(arg_waddr), .wdata(arg_wdata),
    .raddr(arg_raddr), .rdata(arg_rdata)
  );

  hs_sdp_ram #(.DEPTH(BUF_DEPTH), .W(BYTE_W)) u_rsp_ram (
    .clk, .we(rsp_we), .waddr(rsp_waddr), .wdata(rsp_wdata),
    .raddr(rsp_raddr), .rdata(rsp_rdata)
  );

endmodule

// File: tb/tb_hs_cmd_seq.sv
module tb_hs_cmd_seq;

  logic       clk = 0;
  logic       rst = 1;
  logic       port_we = 0;
  logic [7:0] port_wdata = 8'h18;
  logic [7:0] port_q;
  logic       sr_to_dev = 1;
  logic [7:0] sr_wdata = 0;
  logic [7:0] sr_rdata;
  logic       sr_done;
  logic       disp_req;
  logic [7:0] disp_cmd, disp_argc;
  logic [4:0] arg_raddr = 0;
  logic [7:0] arg_rdata;
  logic       disp_done = 0;
  logic       disp_hit = 0;
  logic [7:0] disp_len = 0;
  logic       rsp_we = 0;
  logic [4:0] rsp_waddr = 0;
  logic [7:0] rsp_wdata = 0;

  int total = 0, bad = 0, done_cnt = 0, cyc = 0;
  logic [7:0] exp_cmd, exp_argc, exp_dlen;
  logic       exp_hit;

  always #10 clk = ~clk;

  hs_cmd_seq dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sr_done) done_cnt <= done_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_port(input logic [7:0] v);
    @(negedge clk); port_wdata = v; port_we = 1;
    @(negedge clk); port_we = 0;
  endtask

  task automatic wait_ack(input logic lvl, input string tag);
    bit ok = 0;
    for (int i = 0; i < 400; i++) begin
      if (port_q[3] == lvl) begin ok = 1; break; end
      @(negedge clk);
    end
    check(ok, tag, port_q, {4'h0, lvl, 3'b0});
  endtask

  // one full four-phase byte cycle; returns byte seen and strobe count
  task automatic xfer(input bit to_dev, input logic [7:0] wb,
                      output logic [7:0] rb, output int ndone);
    int d0;
    sr_to_dev = to_dev; sr_wdata = wb; d0 = done_cnt;
    put_port(8'h08);
    wait_ack(0, "R3 ack low");
    @(negedge clk);
    rb = sr_rdata; ndone = done_cnt - d0;
    put_port(8'h10);
    wait_ack(1, "R4 ack high");
    check(port_q == 8'h18, "R4 release port", port_q, 8'h18);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] rb; int nd;
    xfer(1, b, rb, nd);
    check(nd == 1, "R3 byte strobe", nd, 1);
  endtask

  task automatic recv(input logic [7:0] exp, input string tag);
    logic [7:0] rb; int nd;
    xfer(0, 8'h00, rb, nd);
    check(nd == 1 && rb == exp, tag, rb, exp);
  endtask

  task automatic run_cmd(input logic [7:0] c, input logic [7:0] n, input bit wrong);
    logic [2:0] al = c[2:0];
    logic [2:0] rl = c[5:3];
    int cnt;
    logic [7:0] rb; int nd;
    exp_cmd  = c;
    exp_argc = (al == 3'd7) ? n : {5'd0, al};
    exp_hit  = (c[7:6] != 2'b11);
    exp_dlen = (rl == 3'd7) ? 8'd3 : {5'd0, rl};
    send(c);
    if (al == 3'd7) send(n);                               // R8
    for (int i = 0; i < exp_argc; i++) send(8'hA0 + 8'(i));
    if (wrong) begin
      xfer(1, 8'h55, rb, nd);                              // R6 reply phase
      check(nd == 0, "R6 reply dir skip", nd, 0);
    end
    if (rl == 3'd7) begin                                  // R11 / R12
      cnt = exp_hit ? exp_dlen : 0;
      recv(8'(cnt), exp_hit ? "R11 inband size" : "R12 zero size");
    end else cnt = rl;                                     // R7
    for (int i = 0; i < cnt; i++)
      recv((exp_hit && i < exp_dlen) ? c + 8'(i) + 8'd1 : 8'h00,
           exp_hit ? "R10 reply byte" : "R12 zero reply");
    @(negedge clk);
    check(!disp_req, "R10 back to idle", disp_req, 0);
  endtask

  // bench dispatcher
  initial begin
    forever begin
      @(negedge clk);
      if (disp_req) begin
        int nrd;
        check(disp_cmd == exp_cmd, "R9 disp cmd", disp_cmd, exp_cmd);
        check(disp_argc == exp_argc, "R9 disp argc", disp_argc, exp_argc);
        nrd = (exp_argc > 32) ? 32 : exp_argc;             // R13
        for (int i = 0; i < nrd; i++) begin
          arg_raddr = 5'(i);
          @(negedge clk); @(negedge clk);
          check(arg_rdata == 8'hA0 + 8'(i), "R9 R13 arg byte", arg_rdata, 8'hA0 + 8'(i));
        end
        for (int i = 0; i < exp_dlen; i++) begin
          rsp_we = 1; rsp_waddr = 5'(i); rsp_wdata = exp_cmd + 8'(i) + 8'd1;
          @(negedge clk);
        end
        rsp_we = 0;
        disp_hit = exp_hit; disp_len = exp_dlen; disp_done = 1;
        @(negedge clk);
        disp_done = 0;
        while (disp_req) @(negedge clk);
      end
    end
  end

  initial begin
    int d0;
    logic [7:0] rb; int nd;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(port_q == 8'h18, "R1 reset port", port_q, 8'h18);
    check(!disp_req && !sr_done, "R1 reset idle", {disp_req, sr_done}, 0);

    d0 = done_cnt;                                         // R2
    put_port(8'h18);
    repeat (4) @(negedge clk);
    check(port_q == 8'h18 && done_cnt == d0, "R2 same value no-op", port_q, 8'h18);

    put_port(8'h00);                                       // R5
    repeat (4) @(negedge clk);
    check(port_q == 8'h00 && done_cnt == d0, "R5 error ignored", port_q, 8'h00);
    put_port(8'h18);
    repeat (3) @(negedge clk);

    xfer(0, 8'h00, rb, nd);                                // R6 idle phase
    check(nd == 0 && !disp_req, "R6 idle dir skip", nd, 0);

    for (int c = 0; c < 256; c++) run_cmd(8'(c), 8'(c % 5), 1'b0);
    run_cmd(8'h10, 8'h00, 1'b1);                           // R6 in reply
    run_cmd(8'h3F, 8'd40, 1'b0);                           // R13 overflow
    run_cmd(8'hFF, 8'd33, 1'b0);                           // R13 + R12

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule